// File: doc/BRIEF.md
# Self-Stabilizing Token Ring

This block models a ring of processing nodes that share one mutual-exclusion privilege. Each node keeps a small counter. Node 0 holds the privilege when its counter equals the counter of the last node in the ring. Any other node holds it when its counter differs from the counter of its predecessor. The privilege is called a token. In each clock cycle at most one privileged node may move. Node 0 moves by advancing its counter modulo `VAL_MOD`. Any other node moves by copying its predecessor's counter.

A scheduler decides which node moves. In the selected mode an index on `step_sel` names the node. In the round-robin mode the block picks the first privileged node at or after a rotating pointer. A fault port writes any value into any node's register. The ring then works its way back to exactly one circulating token by itself, with no reset. The outputs are the counters, the token flags and a flag that reports a legitimate state (exactly one token).

All pins are plain control and status pins. There is no data stream, and so there is no valid/ready handshake. A step request is taken in the cycle it is presented and is never back-pressured. A request that cannot move any node is dropped.

Top module: `ss_token_ring`

## Requirements
- R1: While `rst_n` is low, every counter and the round-robin pointer clear to 0. The state just after reset therefore shows `token` = 5'b00001 and `legit` = 1.
- R2: Node 0 is privileged when its counter equals the counter of node NODES-1. When it moves, it advances by one, and VAL_MOD-1 wraps to 0.
- R3: Node i (i>0) is privileged when its counter differs from the counter of node i-1. When it moves, it takes the value of node i-1.
- R4: Selected mode (`rr_mode`=0) with `step_valid`=1 moves node `step_sel` only if that node is privileged. A non-privileged node, or an index of NODES or more, leaves every counter unchanged.
- R5: No more than one node changes its counter in any cycle.
- R6: Round-robin mode (`rr_mode`=1) with `step_valid`=1 ignores `step_sel`. It moves the lowest-index privileged node at or after the pointer, wrapping past NODES-1 to 0. The pointer then becomes that node's index plus one, modulo NODES. The pointer changes only on such steps.
- R7: Bit i of `token` equals node i's privilege condition. `legit` is 1 exactly when one bit of `token` is set.
- R8: `inj_en`=1 writes `inj_val` into node `inj_node` within one cycle. A value of VAL_MOD or more is stored as `inj_val`-VAL_MOD. An `inj_node` of NODES or more writes nothing. No step takes effect in an injection cycle.
- R9: From any injected state, round-robin steps reach `legit`=1 within 4*NODES*NODES steps.
- R10: Once `legit` is 1, it stays 1 while no injection occurs. From all zeros, the counters run 00000, 10000, 11000, 11100, 11110, 11111, 21111 (node 0 first).
- R11: With `step_valid`=0 and `inj_en`=0, no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | Request one scheduler step this cycle |
| rr_mode | input | 1 | 1: round-robin pick, 0: use `step_sel` |
| step_sel | input | IW | Node index for the selected mode |
| inj_en | input | 1 | Fault write enable |
| inj_node | input | IW | Node written by the fault port |
| inj_val | input | VW | Value written by the fault port |
| node_vals | output | NODES*VW | Counters, node i at bits [i*VW +: VW] |
| token | output | NODES | Per-node privilege flags |
| legit | output | 1 | Exactly one token present |

## Verification
The assertions assume that no step and no injection happen in the same cycle. The scheduler enforces this by dropping the step, and the bench drives such overlapping cycles to confirm it. The closure and range properties rely on `VAL_MOD` being at least NODES+1, which the top enforces. They also rely on injected values passing through the reduction before they reach a register. The stimulus includes out-of-range node indices and values above the modulus, so the reduction path and the drop path are both exercised, not only the in-range cases.

// File: rtl/sstr_pkg.sv
package sstr_pkg;
  // Wrap-around increment used by the root node.
  function automatic int wrap_inc(input int v, input int m);
    return (v + 1 >= m) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/sstr_node.sv
module sstr_node #(
  parameter int VW    = 3,
  parameter int MOD   = 6,
  parameter bit FIRST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] pred,
  input  logic          wr_en,
  input  logic [VW-1:0] wr_val,
  input  logic          mv,
  output logic [VW-1:0] val,
  output logic          priv
);
  import sstr_pkg::*;
  logic [VW-1:0] nxt;

  always_comb begin
    if (FIRST) begin
      priv = (val == pred);
      nxt  = VW'(wrap_inc(int'(val), MOD));
    end else begin
      priv = (val != pred);
      nxt  = pred;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     val <= '0;
    else if (wr_en) val <= wr_val;
    else if (mv)    val <= nxt;
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mv && !wr_en) |=> $stable(val));
  a_r8_inj_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (int'(val) < MOD));

  if (FIRST) begin : g_root
    a_r2_root_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (mv && !wr_en) |=> (val != $past(val)));
  end else begin : g_follow
    a_r3_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (mv && !wr_en) |=> (val == $past(pred)));
  end
endmodule

// File: rtl/sstr_sched.sv
module sstr_sched #(
  parameter int NODES = 5,
  parameter int IW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic             rr_mode,
  input  logic [IW-1:0]    sel,
  input  logic             inj_en,
  input  logic [NODES-1:0] priv,
  output logic [NODES-1:0] mv
);
  logic [IW-1:0] ptr;
  logic          found;
  int            pick;
  int            idx;
  logic          go;

  assign go = step_valid && !inj_en;

  always_comb begin
    found = 1'b0;
    pick  = 0;
    idx   = 0;
    for (int k = 0; k < NODES; k++) begin
      idx = int'(ptr) + k;
      if (idx >= NODES) idx = idx - NODES;
      if (!found && priv[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  for (genvar i = 0; i < NODES; i++) begin : g_mv
    assign mv[i] = go && (rr_mode ? (found && pick == i)
                                  : (int'(sel) == i && priv[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (go && rr_mode && found)
      ptr <= (pick == NODES - 1) ? '0 : IW'(pick + 1);
  end

  a_r5_one_mover: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mv));
  a_r6_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NODES);
  a_r8_no_step_on_inj: assert property (@(posedge clk) disable iff (!rst_n)
    inj_en |-> (mv == '0));
endmodule

// File: rtl/sstr_legit.sv
module sstr_legit #(
  parameter int NODES = 5
) (
  input  logic [NODES-1:0] tok,
  output logic             legit
);
  localparam int CW = $clog2(NODES + 1);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NODES; i++) cnt = cnt + CW'(tok[i]);
    legit = (cnt == CW'(1));
  end
endmodule

// File: rtl/ss_token_ring.sv
module ss_token_ring #(
  parameter int NODES   = 5,
  parameter int VAL_MOD = NODES + 1,
  localparam int MOD    = (VAL_MOD > NODES) ? VAL_MOD : NODES + 1,
  localparam int VW     = $clog2(MOD),
  localparam int IW     = $clog2(NODES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_valid,
  input  logic                rr_mode,
  input  logic [IW-1:0]       step_sel,
  input  logic                inj_en,
  input  logic [IW-1:0]       inj_node,
  input  logic [VW-1:0]       inj_val,
  output logic [NODES*VW-1:0] node_vals,
  output logic [NODES-1:0]    token,
  output logic                legit
);
  logic [VW-1:0]    vals [NODES];
  logic [NODES-1:0] mv;
  logic [VW-1:0]    wr_val;

  assign wr_val = (int'(inj_val) >= MOD) ? inj_val - VW'(MOD) : inj_val;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    logic [VW-1:0] pred;
    logic          wr_en;
    assign pred  = vals[(i == 0) ? NODES - 1 : i - 1];
    assign wr_en = inj_en && (int'(inj_node) == i);
    sstr_node #(.VW(VW), .MOD(MOD), .FIRST(i == 0)) node_i (
      .clk(clk), .rst_n(rst_n), .pred(pred), .wr_en(wr_en),
      .wr_val(wr_val), .mv(mv[i]), .val(vals[i]), .priv(token[i])
    );
    assign node_vals[i*VW +: VW] = vals[i];
  end

  sstr_sched #(.NODES(NODES), .IW(IW)) sched_i (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .rr_mode(rr_mode),
    .sel(step_sel), .inj_en(inj_en), .priv(token), .mv(mv)
  );

  sstr_legit #(.NODES(NODES)) legit_i (.tok(token), .legit(legit));

  a_r10_closure: assert property (@(posedge clk) disable iff (!rst_n)
    (legit && !inj_en) |=> legit);
endmodule

// File: tb/ss_token_ring_tb.sv
module ss_token_ring_tb_top;
  localparam int N = 5, MODV = 6, VW = 3, IW = 3;
  localparam int BOUND = 4 * N * N;

  logic clk = 1'b0, rst_n = 1'b0;
  logic step_valid = 1'b0, rr_mode = 1'b0, inj_en = 1'b0;
  logic [IW-1:0] step_sel = '0, inj_node = '0;
  logic [VW-1:0] inj_val = '0;
  logic [N*VW-1:0] node_vals;
  logic [N-1:0] token;
  logic legit;

  int m [N];
  int ptr = 0;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  ss_token_ring #(.NODES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .rr_mode(rr_mode),
    .step_sel(step_sel), .inj_en(inj_en), .inj_node(inj_node),
    .inj_val(inj_val), .node_vals(node_vals), .token(token), .legit(legit)
  );

  function automatic bit mpriv(int i);
    return (i == 0) ? (m[0] == m[N-1]) : (m[i] != m[i-1]);
  endfunction

  function automatic logic [N-1:0] mtok();
    logic [N-1:0] t;
    for (int i = 0; i < N; i++) t[i] = mpriv(i);
    return t;
  endfunction

  function automatic bit mlegit();
    return $countones(mtok()) == 1;
  endfunction

  task automatic model_move(int i);
    if (i == 0) m[0] = (m[0] + 1) % MODV;
    else        m[i] = m[i-1];
  endtask

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    int bad = 0;
    for (int i = 0; i < N; i++)
      if (int'(node_vals[i*VW +: VW]) != m[i]) bad++;
    tests++;
    if (bad != 0 || token != mtok() || legit != mlegit()) begin
      fails++;
      $display("FAIL %s actual vals=%h tok=%b legit=%0b expected tok=%b legit=%0b (%0d value mismatches)",
               tag, node_vals, token, legit, mtok(), mlegit(), bad);
    end
  endtask

  // Drive one cycle at the negedge, update the model at the posedge, and compare at the next negedge.
  task automatic cyc(bit sv, bit rr, int sel, bit ie, int nd, int v, string tag);
    @(negedge clk);
    step_valid = sv; rr_mode = rr; step_sel = IW'(sel);
    inj_en = ie; inj_node = IW'(nd); inj_val = VW'(v);
    @(posedge clk);
    if (ie) begin
      if (nd < N) m[nd] = (v >= MODV) ? v - MODV : v;
    end else if (sv) begin
      if (rr) begin
        for (int k = 0; k < N; k++) begin
          int idx = (ptr + k) % N;
          if (mpriv(idx)) begin
            model_move(idx);
            ptr = (idx + 1) % N;
            break;
          end
        end
      end else if (sel < N && mpriv(sel)) model_move(sel);
    end
    @(negedge clk);
    step_valid = 1'b0; inj_en = 1'b0;
    check_all(tag);
  endtask

  task automatic load(int a, int b, int c, int d, int e, string tag);
    int v [N] = '{a, b, c, d, e};
    for (int i = 0; i < N; i++) cyc(0, 0, 0, 1, i, v[i], tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    for (int i = 0; i < N; i++) m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset state");
    check("R1 token after reset", int'(token), 1);
    check("R1 legit after reset", int'(legit), 1);
    rst_n = 1'b1;

    // R10: sequence from all zeros
    for (int s = 0; s < 6; s++) cyc(1, 1, 0, 0, 0, 0, "R10 sequence");
    check("R10 node0 after six steps", int'(node_vals[0 +: VW]), 2);
    check("R10 node4 after six steps", int'(node_vals[4*VW +: VW]), 1);
    cyc(0, 0, 0, 0, 0, 0, "R11 idle");

    // R7: faulted example with tokens at indices 1, 3 and 4
    load(3, 4, 4, 1, 0, "R8 load");
    check("R7 token pattern", int'(token), 5'b11010);
    check("R7 legit low", int'(legit), 0);
    cyc(1, 0, 2, 0, 0, 0, "R4 unprivileged select");
    cyc(1, 0, 6, 0, 0, 0, "R4 out of range select");
    cyc(1, 0, 3, 0, 0, 0, "R3 copy");
    check("R3 node3 copied", int'(node_vals[3*VW +: VW]), 4);

    // R2: wrap
    load(5, 5, 5, 5, 5, "R8 load");
    cyc(1, 0, 0, 0, 0, 0, "R2 wrap");
    check("R2 node0 wrapped", int'(node_vals[0 +: VW]), 0);

    // R8: out-of-range value, bad node, injection beats step
    cyc(0, 0, 0, 1, 2, 7, "R8 reduce");
    check("R8 reduced value", int'(node_vals[2*VW +: VW]), 1);
    cyc(0, 0, 0, 1, 7, 3, "R8 bad node");
    cyc(1, 1, 0, 1, 1, 4, "R8 inject with step");

    // R6 / R4: random mix
    for (int t = 0; t < 300; t++) begin
      int r = $urandom_range(0, 9);
      if (r < 2) cyc(0, 0, 0, 1, $urandom_range(0, 7), $urandom_range(0, 7), "R8 random");
      else if (r < 5) cyc(1, 0, $urandom_range(0, 7), 0, 0, 0, "R4 random");
      else if (r < 9) cyc(1, 1, $urandom_range(0, 7), 0, 0, 0, "R6 random");
      else cyc(0, 0, 0, 0, 0, 0, "R11 random");
    end

    // R9 / R10: convergence from random states, then closure
    for (int trial = 0; trial < 30; trial++) begin
      int steps = 0;
      for (int i = 0; i < N; i++) cyc(0, 0, 0, 1, i, $urandom_range(0, MODV-1), "R8 scramble");
      while (!legit && steps < BOUND) begin
        cyc(1, 1, $urandom_range(0, 7), 0, 0, 0, "R9 converge");
        steps++;
      end
      check("R9 legit within bound", int'(legit), 1);
      for (int s = 0; s < 2*N; s++) cyc(1, 1, 0, 0, 0, 0, "R10 closure");
      check("R10 still legit", int'(legit), 1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule